// File: doc/BRIEF.md
# Indirect Register Access Controller

This block lets a byte-wide processor port reach internal resources that cannot be wired straight onto the register bus. These resources are a small external-style byte memory, a bank of wide event counters, and a cell buffer that is moved into the memory over many cycles. The processor first loads a 24-bit target address into three byte staging registers. For a memory write it also loads a data staging register. It then writes a command byte with the go bit (bit 6) set into one of three command registers. At that moment the controller copies the staged address and data into private transfer registers, so later writes to the staging registers cannot disturb the transfer in flight.

Each command register reports its own readiness in bit 7. That bit drops to 0 on the cycle the command is taken and returns to 1 when the transfer finishes. Every finished transfer sets a sticky done flag. A command that arrives while another transfer is running is dropped and sets a sticky error flag. Either flag can drive the interrupt output through an enable mask. Direct memory access is only possible after a three-step unlock sequence. Counter reads capture the selected counter in one cycle, so the value read back stays fixed while the counter keeps running.

Register offsets: 0/1/2 address bytes (low to high), 3 data (write: staged data, read: last memory read result), 4 memory control, 5 test enable, 6 link select, 7 counter command, 8/9/10 counter copy bytes (low to high), 11 cell command, 12 cell fill, 13 status, 14 interrupt enable.

Top module: `iac_ctrl`

## Requirements
- R1: After reset, offsets 4, 7 and 11 read 0x80 (ready, locked), status (offset 13) reads 0 and irq is 0.
- R2: Memory commands are honoured only after offset 5 bit 7 is set, offset 6 holds 0x10 and 0x29 is then written to offset 4. Offset 4 bit 0 shows the unlocked state. A memory command given while locked changes neither the memory, nor offset 4 bit 7, nor the status.
- R3: A memory write (0x41 to offset 4) stores the staged data byte at the staged address. Offset 4 bit 7 reads 0 for exactly MEM_LAT cycles after the command cycle and reads 1 afterwards.
- R4: A memory read (0x40 to offset 4) lasts MEM_LAT cycles and leaves the addressed byte readable at offset 3. Only the low MEM_AW bits of the 24-bit address select the location.
- R5: Writes to the address or data staging registers while a transfer runs do not change the location or data of that transfer.
- R6: A counter command (bit 6 set, bits 1:0 the counter index, to offset 7) copies that counter into offsets 8..10 in the command cycle. Bit 7 reads 0 for CNT_LAT cycles. Events counted after the command do not alter the copy.
- R7: A cell command (0x40 to offset 11) writes the CELL_BYTES bytes loaded through offset 12 (in write order, the pointer restarting at each cell command) to memory at the staged address plus the byte index. Offset 11 bit 7 reads 0 for CELL_BYTES*CELL_STEP cycles.
- R8: A command issued while any transfer is running is ignored: the command register's ready bit and the target state do not change. Status bit 1 becomes 1.
- R9: Status bit 0 becomes 1 when any transfer completes. Writing offset 13 clears each status bit whose written bit is 0 and keeps each bit whose written bit is 1.
- R10: irq is 1 exactly when some status bit and the matching bit of offset 14 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, taken on the rising edge |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| cnt_evt | input | NUM_CNT | Per-counter increment events |
| irq | output | 1 | Interrupt request |

## Verification
A transfer engine that ends one cycle early or late shows up directly as a wrong count of cycles during which a ready bit reads 0. That count is visible on the first poll after the command. A transfer copy register that is not isolated from staging shows up as a wrong byte at the memory location read back right after the transfer. A counter copy that keeps tracking the live counter returns a larger value than the bench's own count of events at the command. A lost or stuck sticky flag shows on irq and at offset 13 on the cycle after the event or the clearing write.

// File: rtl/iac_pkg.sv
package iac_pkg;

  typedef enum logic [1:0] {
    XK_MRD  = 2'd0,
    XK_MWR  = 2'd1,
    XK_CNT  = 2'd2,
    XK_CELL = 2'd3
  } xfer_kind_t;

  localparam logic [3:0] RA_ADR0  = 4'd0;
  localparam logic [3:0] RA_ADR1  = 4'd1;
  localparam logic [3:0] RA_ADR2  = 4'd2;
  localparam logic [3:0] RA_DATA  = 4'd3;
  localparam logic [3:0] RA_MCTL  = 4'd4;
  localparam logic [3:0] RA_TEN   = 4'd5;
  localparam logic [3:0] RA_LINK  = 4'd6;
  localparam logic [3:0] RA_CCMD  = 4'd7;
  localparam logic [3:0] RA_CV0   = 4'd8;
  localparam logic [3:0] RA_CV1   = 4'd9;
  localparam logic [3:0] RA_CV2   = 4'd10;
  localparam logic [3:0] RA_XCMD  = 4'd11;
  localparam logic [3:0] RA_XFILL = 4'd12;
  localparam logic [3:0] RA_STAT  = 4'd13;
  localparam logic [3:0] RA_IEN   = 4'd14;

  localparam logic [7:0] UNLOCK_KEY = 8'h29;
  localparam logic [7:0] LINK_KEY   = 8'h10;
  localparam int         GO_BIT     = 6;
  localparam int         RDY_BIT    = 7;

  // pick one byte of a 24-bit value, 0 = least significant
  function automatic logic [7:0] byte_of(logic [23:0] v, logic [1:0] n);
    case (n)
      2'd0:    return v[7:0];
      2'd1:    return v[15:8];
      default: return v[23:16];
    endcase
  endfunction

endpackage

// File: rtl/iac_sram.sv
module iac_sram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/iac_cntbank.sv
module iac_cntbank #(
  parameter int NUM = 4,
  parameter int W   = 24,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] inc,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   value
);
  logic [W-1:0] cnt [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign value = cnt[sel];
endmodule

// File: rtl/iac_engine.sv
module iac_engine
  import iac_pkg::*;
#(
  parameter int MEM_LAT    = 3,
  parameter int CNT_LAT    = 4,
  parameter int CELL_BYTES = 53,
  parameter int CELL_STEP  = 4,
  parameter int IW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  xfer_kind_t    kind_in,
  output logic          busy,
  output xfer_kind_t    kind,
  output logic          step,
  output logic          fin,
  output logic [IW-1:0] idx
);
  localparam int LEN_A  = (MEM_LAT > CNT_LAT) ? MEM_LAT : CNT_LAT;
  localparam int MAXLEN = (LEN_A > CELL_STEP) ? LEN_A : CELL_STEP;
  localparam int PW     = $clog2(MAXLEN + 1);

  logic [PW-1:0] phase;

  // cycles spent on one step of a transfer of the given kind
  function automatic logic [PW-1:0] len_of(xfer_kind_t k);
    case (k)
      XK_CNT:  return PW'(CNT_LAT);
      XK_CELL: return PW'(CELL_STEP);
      default: return PW'(MEM_LAT);
    endcase
  endfunction

  // index of the final step
  function automatic logic [IW-1:0] last_of(xfer_kind_t k);
    return (k == XK_CELL) ? IW'(CELL_BYTES - 1) : '0;
  endfunction

  assign step = busy && (phase == len_of(kind) - PW'(1));
  assign fin  = step && (idx == last_of(kind));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      kind  <= XK_MRD;
      phase <= '0;
      idx   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        kind  <= kind_in;
        phase <= '0;
        idx   <= '0;
      end
    end else if (step) begin
      phase <= '0;
      if (fin) busy <= 1'b0;
      else     idx  <= idx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  AST_FIN_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy); // R7

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= IW'(CELL_BYTES - 1))); // R7
endmodule

// File: rtl/iac_ctrl.sv
module iac_ctrl
  import iac_pkg::*;
#(
  parameter int NUM_CNT    = 4,
  parameter int CNT_W      = 24,
  parameter int MEM_AW     = 6,
  parameter int MEM_LAT    = 3,
  parameter int CNT_LAT    = 4,
  parameter int CELL_BYTES = 53,
  parameter int CELL_STEP  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [NUM_CNT-1:0] cnt_evt,
  output logic               irq
);
  localparam int IW = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1;
  localparam int SW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  // staging (processor side)
  logic [7:0]  adr0, adr1, adr2, wr_stg, ten_q, link_q;
  logic        unlocked;
  // transfer copies (engine side)
  logic [23:0] xfer_addr, cnt_copy;
  logic [7:0]  xfer_data, rd_copy;
  logic [SW-1:0] cnt_sel;
  logic        mem_rdy, cnt_rdy, cell_rdy;
  logic [1:0]  status, irq_en;
  logic [7:0]  cellbuf [CELL_BYTES];
  logic [IW-1:0] fill_ptr;

  // named internal events
  logic        wr_mctl, mem_cmd, cnt_cmd, cell_cmd, cmd_req, accept, collide;
  logic        unlock_hit, lock_drop;
  xfer_kind_t  req_kind;
  logic        busy, step, fin;
  xfer_kind_t  kind;
  logic [IW-1:0] idx;
  logic [CNT_W-1:0] cnt_val;
  logic        sram_we;
  logic [MEM_AW-1:0] slot;
  logic [7:0]  sram_wdata, sram_rdata;

  // memory location for step off of a transfer based at base
  function automatic logic [MEM_AW-1:0] mem_slot(logic [23:0] base, logic [IW-1:0] off);
    logic [23:0] s;
    s = base + 24'(off);
    return s[MEM_AW-1:0];
  endfunction

  assign wr_mctl    = reg_we && (reg_addr == RA_MCTL);
  assign unlock_hit = wr_mctl && (reg_wdata == UNLOCK_KEY) && ten_q[7] && (link_q == LINK_KEY);
  assign lock_drop  = reg_we && (reg_addr == RA_TEN) && !reg_wdata[7];
  assign mem_cmd    = wr_mctl && reg_wdata[GO_BIT] && unlocked;
  assign cnt_cmd    = reg_we && (reg_addr == RA_CCMD) && reg_wdata[GO_BIT];
  assign cell_cmd   = reg_we && (reg_addr == RA_XCMD) && reg_wdata[GO_BIT];
  assign cmd_req    = mem_cmd || cnt_cmd || cell_cmd;
  assign accept     = cmd_req && !busy;
  assign collide    = cmd_req && busy;

  always_comb begin
    if (mem_cmd)      req_kind = reg_wdata[0] ? XK_MWR : XK_MRD;
    else if (cnt_cmd) req_kind = XK_CNT;
    else              req_kind = XK_CELL;
  end

  iac_engine #(
    .MEM_LAT(MEM_LAT), .CNT_LAT(CNT_LAT), .CELL_BYTES(CELL_BYTES),
    .CELL_STEP(CELL_STEP), .IW(IW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(accept), .kind_in(req_kind),
    .busy(busy), .kind(kind), .step(step), .fin(fin), .idx(idx)
  );

  iac_cntbank #(.NUM(NUM_CNT), .W(CNT_W), .SW(SW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_evt), .sel(reg_wdata[SW-1:0]), .value(cnt_val)
  );

  assign slot       = mem_slot(xfer_addr, idx);
  assign sram_we    = step && ((kind == XK_MWR) || (kind == XK_CELL));
  assign sram_wdata = (kind == XK_CELL) ? cellbuf[idx] : xfer_data;

  iac_sram #(.AW(MEM_AW), .DW(8)) u_sram (
    .clk(clk), .rst_n(rst_n), .we(sram_we), .waddr(slot), .wdata(sram_wdata),
    .raddr(slot), .rdata(sram_rdata)
  );

  // cell buffer fill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CELL_BYTES; i++) cellbuf[i] <= '0;
      fill_ptr <= '0;
    end else if (accept && (req_kind == XK_CELL)) begin
      fill_ptr <= '0;
    end else if (reg_we && (reg_addr == RA_XFILL)) begin
      cellbuf[fill_ptr] <= reg_wdata;
      fill_ptr <= (fill_ptr == IW'(CELL_BYTES - 1)) ? '0 : fill_ptr + 1'b1;
    end
  end

  // staging, unlock, copies, ready bits, status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr0 <= '0; adr1 <= '0; adr2 <= '0; wr_stg <= '0;
      ten_q <= '0; link_q <= '0; unlocked <= 1'b0;
      xfer_addr <= '0; xfer_data <= '0; rd_copy <= '0;
      cnt_copy <= '0; cnt_sel <= '0;
      mem_rdy <= 1'b1; cnt_rdy <= 1'b1; cell_rdy <= 1'b1;
      status <= '0; irq_en <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_ADR0: adr0   <= reg_wdata;
          RA_ADR1: adr1   <= reg_wdata;
          RA_ADR2: adr2   <= reg_wdata;
          RA_DATA: wr_stg <= reg_wdata;
          RA_TEN:  ten_q  <= reg_wdata;
          RA_LINK: link_q <= reg_wdata;
          RA_IEN:  irq_en <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (unlock_hit)     unlocked <= 1'b1;
      else if (lock_drop) unlocked <= 1'b0;

      if (accept) begin
        xfer_addr <= {adr2, adr1, adr0};
        xfer_data <= wr_stg;
        case (req_kind)
          XK_CNT: begin
            cnt_rdy  <= 1'b0;
            cnt_copy <= 24'(cnt_val);
            cnt_sel  <= reg_wdata[SW-1:0];
          end
          XK_CELL: cell_rdy <= 1'b0;
          default: mem_rdy  <= 1'b0;
        endcase
      end

      if (step && (kind == XK_MRD)) rd_copy <= sram_rdata;

      if (fin) begin
        case (kind)
          XK_CNT:  cnt_rdy  <= 1'b1;
          XK_CELL: cell_rdy <= 1'b1;
          default: mem_rdy  <= 1'b1;
        endcase
      end

      if (reg_we && (reg_addr == RA_STAT)) status <= (status & reg_wdata[1:0]) | {collide, fin};
      else                                 status <= status | {collide, fin};
    end
  end

  assign irq = |(status & irq_en);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_ADR0:  reg_rdata = adr0;
      RA_ADR1:  reg_rdata = adr1;
      RA_ADR2:  reg_rdata = adr2;
      RA_DATA:  reg_rdata = rd_copy;
      RA_MCTL:  begin reg_rdata[RDY_BIT] = mem_rdy; reg_rdata[0] = unlocked; end
      RA_TEN:   reg_rdata = ten_q;
      RA_LINK:  reg_rdata = link_q;
      RA_CCMD:  begin reg_rdata[RDY_BIT] = cnt_rdy; reg_rdata[SW-1:0] = cnt_sel; end
      RA_CV0:   reg_rdata = byte_of(cnt_copy, 2'd0);
      RA_CV1:   reg_rdata = byte_of(cnt_copy, 2'd1);
      RA_CV2:   reg_rdata = byte_of(cnt_copy, 2'd2);
      RA_XCMD:  reg_rdata[RDY_BIT] = cell_rdy;
      RA_STAT:  reg_rdata[1:0] = status;
      RA_IEN:   reg_rdata[1:0] = irq_en;
      default:  reg_rdata = '0;
    endcase
  end

  AST_LOCKED_NO_MEMOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && ((kind == XK_MRD) || (kind == XK_MWR))) |-> $past(unlocked)); // R2

  AST_MWR_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (kind == XK_MWR)) |-> !mem_rdy); // R3

  AST_COPY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (kind == XK_CNT)) |-> $stable(cnt_copy)); // R6

  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> status[1]); // R8

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> status[0]); // R9
endmodule

// File: tb/iac_ctrl_bench.sv
module iac_ctrl_bench;
  localparam int PERIOD   = 10;
  localparam int MEM_LAT  = 3;
  localparam int CNT_LAT  = 4;
  localparam int CBYTES   = 53;
  localparam int CSTEP    = 4;
  localparam int WD_LIMIT = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] cnt_evt = '0;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  iac_ctrl #(
    .NUM_CNT(4), .CNT_W(24), .MEM_AW(6), .MEM_LAT(MEM_LAT),
    .CNT_LAT(CNT_LAT), .CELL_BYTES(CBYTES), .CELL_STEP(CSTEP)
  ) u_iac_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_evt(cnt_evt), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  // count cycles with bit 7 of register a low, starting at the current negedge
  task automatic wait_rdy(input logic [3:0] a, output int n);
    logic [7:0] v;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      peek(a, v);
      if (v[7]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_addr(input logic [23:0] ad);
    wr(4'd0, ad[7:0]); wr(4'd1, ad[15:8]); wr(4'd2, ad[23:16]);
  endtask

  task automatic mem_read(input logic [23:0] ad, output logic [7:0] v, output int n);
    set_addr(ad);
    wr(4'd4, 8'h40);
    wait_rdy(4'd4, n);
    rd(4'd3, v);
  endtask

  task automatic pulse(input int ch, input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk); cnt_evt[ch] = 1'b1;
      @(negedge clk); cnt_evt[ch] = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd4, v);  chk("R1 memctl", v, 8'h80);
    rd(4'd7, v);  chk("R1 cntcmd", v, 8'h80);
    rd(4'd11, v); chk("R1 cellcmd", v, 8'h80);
    rd(4'd13, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    int n;
    set_addr(24'h000005);
    wr(4'd3, 8'hA5);
    wr(4'd4, 8'h41);
    peek(4'd4, v); chk("R2 locked cmd keeps ready", v, 8'h80);
    rd(4'd13, v);  chk("R2 locked cmd no status", v, 8'h00);
    wr(4'd5, 8'h80); wr(4'd6, 8'h11); wr(4'd4, 8'h29);
    rd(4'd4, v);   chk("R2 wrong link stays locked", v, 8'h80);
    wr(4'd6, 8'h10); wr(4'd4, 8'h29);
    rd(4'd4, v);   chk("R2 unlocked", v, 8'h81);
    mem_read(24'h000005, v, n);
    chk("R2 locked write left memory", v, 8'h00);
    chk("R4 read busy cycles", n, MEM_LAT);
  endtask

  task automatic t_mem_rw();
    logic [7:0] v;
    int n;
    set_addr(24'h123407);
    wr(4'd3, 8'h5C);
    wr(4'd4, 8'h41);
    wait_rdy(4'd4, n);
    chk("R3 write busy cycles", n, MEM_LAT);
    rd(4'd4, v); chk("R3 ready back", v, 8'h81);
    mem_read(24'h000007, v, n);
    chk("R4 read data", v, 8'h5C);
    mem_read(24'hFFFF47, v, n);
    chk("R4 low address bits only", v, 8'h5C);
  endtask

  task automatic t_staging();
    logic [7:0] v;
    int n;
    set_addr(24'h000009);
    wr(4'd3, 8'h33);
    wr(4'd4, 8'h41);
    wr(4'd0, 8'h0A);
    wr(4'd3, 8'h44);
    wait_rdy(4'd4, n);
    mem_read(24'h000009, v, n);
    chk("R5 data at original address", v, 8'h33);
    mem_read(24'h00000A, v, n);
    chk("R5 new staging address untouched", v, 8'h00);
  endtask

  task automatic t_counter();
    logic [7:0] v;
    int n;
    pulse(2, 5);
    pulse(1, 3);
    wr(4'd7, 8'h42);
    cnt_evt[2] = 1'b1;
    wait_rdy(4'd7, n);
    cnt_evt[2] = 1'b0;
    chk("R6 counter busy cycles", n, CNT_LAT);
    rd(4'd8, v);  chk("R6 copy byte0 frozen", v, 8'd5);
    rd(4'd9, v);  chk("R6 copy byte1", v, 8'd0);
    rd(4'd7, v);  chk("R6 cmd reg ready+sel", v, 8'h82);
    wr(4'd7, 8'h42);
    wait_rdy(4'd7, n);
    rd(4'd8, v);  chk("R6 second read sees later events", v, 8'd5 + CNT_LAT);
    wr(4'd7, 8'h41);
    wait_rdy(4'd7, n);
    rd(4'd8, v);  chk("R6 counter 1", v, 8'd3);
    pulse(0, 300);
    wr(4'd7, 8'h40);
    wait_rdy(4'd7, n);
    rd(4'd8, v);  chk("R6 wide byte0", v, 8'h2C);
    rd(4'd9, v);  chk("R6 wide byte1", v, 8'h01);
    rd(4'd10, v); chk("R6 wide byte2", v, 8'h00);
  endtask

  task automatic t_cell();
    logic [7:0] v;
    int n;
    for (int i = 0; i < CBYTES; i++) wr(4'd12, 8'(i * 3 + 1));
    set_addr(24'h000005);
    wr(4'd13, 8'h00);
    wr(4'd14, 8'h01);
    wr(4'd11, 8'h40);
    chk("R10 irq low while busy", irq, 0);
    wait_rdy(4'd11, n);
    chk("R7 cell busy cycles", n, CBYTES * CSTEP);
    rd(4'd13, v); chk("R9 done flag", v, 8'h01);
    chk("R10 irq on done", irq, 1);
    mem_read(24'h000005, v, n); chk("R7 first byte", v, 8'd1);
    mem_read(24'h00001E, v, n); chk("R7 middle byte", v, 8'd76);
    mem_read(24'h000039, v, n); chk("R7 last byte", v, 8'd157);
    wr(4'd13, 8'hFE);
    rd(4'd13, v); chk("R9 write-zero clears", v, 8'h00);
    chk("R10 irq drops", irq, 0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    int n;
    wr(4'd14, 8'h00);
    set_addr(24'h000010);
    wr(4'd11, 8'h40);
    wr(4'd4, 8'h40);
    wr(4'd7, 8'h41);
    rd(4'd13, v); chk("R8 error flag", v, 8'h02);
    rd(4'd4, v);  chk("R8 memctl ready untouched", v, 8'h81);
    rd(4'd7, v);  chk("R8 cntcmd untouched", v, 8'h80);
    wait_rdy(4'd11, n);
    rd(4'd8, v);  chk("R8 counter copy untouched", v, 8'h2C);
    rd(4'd13, v); chk("R9 both flags", v, 8'h03);
    chk("R10 masked irq", irq, 0);
    wr(4'd14, 8'h02);
    chk("R10 irq from error", irq, 1);
    wr(4'd13, 8'h01);
    rd(4'd13, v); chk("R9 keep bit written 1", v, 8'h01);
    chk("R10 irq after error clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_mem_rw();
    t_staging();
    t_counter();
    t_cell();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule